// File: doc/BRIEF.md
# Message Schedule Word Generator

This block expands one padded 512-bit message block into the 64 schedule words that a 256-bit compression core eats, one word per step. A load strobe captures all sixteen 32-bit words of the block in a single cycle; from then on the block presents the current schedule word on its output and moves to the next one each time the consumer accepts it. The first sixteen words are the message words themselves. Every later word is built from four words held in a sixteen-deep sliding window, two of them passed through small sigma mixing functions.

The four-operand sum goes through two carry-save stages whose sum and carry vectors are registered one step ahead of use. Only a single 32-bit carry-propagate add stands between that register and the window. The output side is a valid/ready stream. `w_valid` says the word on `w_word` is a live schedule word. The consumer raises `w_ready` to take it, and the word advances on that clock edge. While `w_ready` is low the word and `w_valid` hold, so the consumer can apply back-pressure for any number of cycles. `blk_load` is a plain control strobe: it is always accepted, and it takes precedence over any transfer in the same cycle.

Top module: `wsched_gen`

## Requirements
- R1: After reset `w_valid` is low.
- R2: In the cycle after `blk_load` is sampled high, `w_valid` is high and `w_word` equals message word 0. Message word i occupies `blk_words[32*i+31:32*i]`.
- R3: The schedule words with index 0 to 15 are the message words with the same index.
- R4: Each word with index t from 16 to 63 equals s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] modulo 2^32. Here s0(x) = rotr7(x) ^ rotr18(x) ^ (x >> 3) and s1(x) = rotr17(x) ^ rotr19(x) ^ (x >> 10).
- R5: Before the add, the four operands are reduced to a sum and carry pair by two carry-save stages. That pair is registered, so one 32-bit carry-propagate add is the only adder on the path into the window.
- R6: A word is transferred on a clock edge where `w_valid` and `w_ready` are both high, and the next schedule word then appears. With `w_ready` low, `w_word` and `w_valid` hold.
- R7: After exactly 64 transfers following a load, `w_valid` goes low and stays low until the next load, whatever `w_ready` does.
- R8: A load in the middle of a sequence restarts the schedule from word 0 of the new block, even when a transfer would have happened in the same cycle.
- R9: For the padded empty message (word 0 = 0x80000000, all other words zero), word 16 is 0x80000000, word 17 is 0, and word 18 is 0x00205000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_load | input | 1 | Capture `blk_words` and restart the schedule |
| blk_words | input | 512 | Sixteen message words, word i at bits 32*i+31:32*i |
| w_ready | input | 1 | Consumer accepts the current word |
| w_valid | output | 1 | `w_word` holds a live schedule word |
| w_word | output | 32 | Current schedule word |

## Verification
The hardest case to reach is a reload that lands mid-stream in the same cycle as an accepted transfer. It tests the load-over-advance priority and the pre-computed carry-save pair, which must be rebuilt from the new block and not from the shifted window. The stimulus drains part of one random block under a random ready pattern, then raises `blk_load` with `w_ready` held high. A scoreboard fed from an independent model then checks that every word of the new block comes out in order. The tail of a drain is checked as well: after the 64th transfer, with ready held high, `w_valid` must stay low.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t ssig0(input word_t x);
    return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(input word_t x);
    return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x >> 10);
  endfunction

  // 3:2 compressor: returns {carry, sum}, carry already weighted by 2
  function automatic logic [2*WORD_W-1:0] csa3(input word_t a, input word_t b, input word_t c);
    word_t s, m;
    s = a ^ b ^ c;
    m = (a & b) | (a & c) | (b & c);
    return {m[WORD_W-2:0], 1'b0, s};
  endfunction
endpackage

// File: rtl/wsched_window.sv
module wsched_window
  import wsched_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [DEPTH-1:0][WORD_W-1:0] load_words,
  input  logic                   shift,
  input  word_t                  new_word,
  output logic [DEPTH-1:0][WORD_W-1:0] win
);
  // word i of the window is schedule word t+i; new words enter at the top
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    word_t next_in;
    if (i == DEPTH - 1) begin : g_top
      assign next_in = new_word;
    end else begin : g_mid
      assign next_in = win[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     win[i] <= '0;
      else if (load)  win[i] <= load_words[i];
      else if (shift) win[i] <= next_in;
    end
  end

  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (win[0] == $past(win[1])));
endmodule

// File: rtl/wsched_presum.sv
module wsched_presum
  import wsched_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   shift,
  input  logic [DEPTH-1:0][WORD_W-1:0] load_words,
  input  logic [DEPTH-1:0][WORD_W-1:0] win,
  output word_t                  sum_word
);
  localparam int TAP_S1  = DEPTH - 2;
  localparam int TAP_MID = DEPTH - 7;
  localparam int TAP_S0  = 1;
  localparam int TAP_OLD = 0;

  // operands come from the window as it will be after this edge; its top
  // slot (the word being added now) is never a tap, so no CPA feeds back here
  logic [DEPTH-1:0][WORD_W-1:0] nxt;
  assign nxt = load ? load_words : {word_t'('0), win[DEPTH-1:1]};

  word_t op_a, op_b, op_c, op_d;
  assign op_a = ssig1(nxt[TAP_S1]);
  assign op_b = nxt[TAP_MID];
  assign op_c = ssig0(nxt[TAP_S0]);
  assign op_d = nxt[TAP_OLD];

  word_t s1, c1, s2, c2;
  assign {c1, s1} = csa3(op_a, op_b, op_c);
  assign {c2, s2} = csa3(s1, c1, op_d);

  word_t ps_q, pc_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q <= '0;
      pc_q <= '0;
    end else if (load || shift) begin
      ps_q <= s2;
      pc_q <= c2;
    end
  end

  assign sum_word = ps_q + pc_q;

  word_t ref_sum;
  assign ref_sum = op_a + op_b + op_c + op_d;

  assert_csa_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load || shift) |=> (sum_word == $past(ref_sum)));
endmodule

// File: rtl/wsched_ctl.sv
module wsched_ctl #(
  parameter int SCHED_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ready,
  output logic valid,
  output logic adv
);
  localparam int CNT_W = $clog2(SCHED_LEN + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(SCHED_LEN);

  logic [CNT_W-1:0] cnt;

  assign valid = (cnt < DONE);
  assign adv   = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= DONE;
    else if (load) cnt <= '0;
    else if (adv)  cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (rst_n) assert_cnt_bound_R7: assert (cnt <= DONE);
  end

  assert_stay_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !load) |=> !valid);
endmodule

// File: rtl/wsched_gen.sv
module wsched_gen
  import wsched_pkg::*;
#(
  parameter int BLK_WORDS = 16,
  parameter int SCHED_LEN = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          blk_load,
  input  logic [BLK_WORDS*WORD_W-1:0]   blk_words,
  input  logic                          w_ready,
  output logic                          w_valid,
  output logic [WORD_W-1:0]             w_word
);
  logic [BLK_WORDS-1:0][WORD_W-1:0] load_words;
  logic [BLK_WORDS-1:0][WORD_W-1:0] win;
  logic  adv, shift;
  word_t sum_word;

  assign load_words = blk_words;
  assign shift      = adv && !blk_load;

  wsched_ctl #(.SCHED_LEN(SCHED_LEN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .ready(w_ready),
    .valid(w_valid), .adv(adv)
  );

  wsched_presum #(.DEPTH(BLK_WORDS)) u_presum (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .shift(shift),
    .load_words(load_words), .win(win), .sum_word(sum_word)
  );

  wsched_window #(.DEPTH(BLK_WORDS)) u_win (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .load_words(load_words),
    .shift(shift), .new_word(sum_word), .win(win)
  );

  assign w_word = win[0];

  assert_load_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_load |=> (w_valid && w_word == $past(blk_words[WORD_W-1:0])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && !w_ready && !blk_load) |=> (w_valid && $stable(w_word)));
endmodule

// File: tb/wsched_gen_tb.sv
module wsched_gen_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         blk_load = 1'b0;
  logic [511:0] blk_words = '0;
  logic         w_ready = 1'b0;
  logic         w_valid;
  logic [31:0]  w_word;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit empty_run = 1'b0;
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  wsched_gen u_dut (
    .clk(clk), .rst_n(rst_n), .blk_load(blk_load), .blk_words(blk_words),
    .w_ready(w_ready), .w_valid(w_valid), .w_word(w_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_s0(input logic [31:0] x);
    return ((x >> 7) | (x << 25)) ^ ((x >> 18) | (x << 14)) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] m_s1(input logic [31:0] x);
    return ((x >> 17) | (x << 15)) ^ ((x >> 19) | (x << 13)) ^ (x >> 10);
  endfunction

  task automatic fill_expected(input logic [511:0] b);
    logic [31:0] w [64];
    for (int t = 0; t < 64; t++) begin
      if (t < 16) w[t] = b[32*t +: 32];
      else w[t] = m_s1(w[t-2]) + w[t-7] + m_s0(w[t-15]) + w[t-16];
    end
    expq.delete();
    for (int t = 0; t < 64; t++) expq.push_back(w[t]);
  endtask

  // driver: load with the given ready level during the load cycle
  task automatic load_block(input logic [511:0] b, input logic rdy, input string tag);
    @(posedge clk); #1;
    blk_words = b;
    blk_load  = 1'b1;
    w_ready   = rdy;
    @(posedge clk); #1;
    blk_load  = 1'b0;
    w_ready   = 1'b0;
    fill_expected(b);
    @(negedge clk);
    chk(w_valid == 1'b1, tag, {31'b0, w_valid}, 32'h1);
    chk(w_word == b[31:0], tag, w_word, b[31:0]);
  endtask

  task automatic drain_to(input int left, input bit rnd);
    while (expq.size() > left) begin
      @(posedge clk); #1;
      w_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
    end
    @(posedge clk); #1;
    w_ready = 1'b0;
  endtask

  function automatic logic [511:0] rand_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  // monitor: compare the live word with the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      if (w_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R7", w_word, 32'h0);
        end else begin
          automatic int idx = 64 - expq.size();
          chk(w_word == expq[0], (idx < 16) ? "R3" : "R4", w_word, expq[0]);
          if (empty_run && idx == 16) chk(w_word == 32'h80000000, "R9", w_word, 32'h80000000);
          if (empty_run && idx == 17) chk(w_word == 32'h00000000, "R9", w_word, 32'h00000000);
          if (empty_run && idx == 18) chk(w_word == 32'h00205000, "R9", w_word, 32'h00205000);
          if (w_ready && !blk_load) void'(expq.pop_front());
        end
      end else if (expq.size() != 0) begin
        chk(1'b0, "R7", 32'h0, 32'h1);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] blk;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(w_valid == 1'b0, "R1", {31'b0, w_valid}, 32'h0);

    // R9: padded empty message, full-rate consumer
    blk = '0;
    blk[31:0] = 32'h80000000;
    empty_run = 1'b1;
    load_block(blk, 1'b0, "R2");
    drain_to(0, 1'b0);
    empty_run = 1'b0;
    // R7: ready high after the last word, valid must stay low
    @(posedge clk); #1 w_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(w_valid == 1'b0, "R7", {31'b0, w_valid}, 32'h0);
    end

    // random blocks with random back-pressure
    for (int n = 0; n < 4; n++) begin
      load_block(rand_block(), 1'b0, "R2");
      drain_to(0, 1'b1);
    end

    // R6: hold with ready low mid-stream
    load_block(rand_block(), 1'b0, "R2");
    drain_to(40, 1'b0);
    @(negedge clk);
    held = w_word;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(w_word == held && w_valid, "R6", w_word, held);
    end
    drain_to(0, 1'b1);

    // R8: reload mid-sequence, with ready high in the load cycle
    load_block(rand_block(), 1'b0, "R2");
    drain_to(44, 1'b1);
    load_block(rand_block(), 1'b1, "R8");
    drain_to(0, 1'b1);
    // R8: reload during the schedule's second half, ready low
    load_block(rand_block(), 1'b0, "R2");
    drain_to(5, 1'b0);
    load_block(rand_block(), 1'b0, "R8");
    drain_to(0, 1'b0);

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule